// File: doc/BRIEF.md
# MDIO Management Controller

This block runs clause-22 management transactions to an external PHY over a two-wire MDC/MDIO pair. Software talks to it through six small registers: configuration (management reset and MDC clock selection), command (read request and a scan stub), PHY/register address, write data, read data and an indicator register that reports progress. A transaction always sends a full 64-bit frame of 32 preamble ones, start code, opcode, two 5-bit addresses, a turnaround and 16 data bits, most significant bit first.

A write is started simply by storing a value into the write-data register. A read is started by setting bit 0 of the command register. Its result lands in the read-data register, and the not-valid indicator clears at that moment. MDC is derived from the system clock by a divider whose ratio is chosen by a 4-bit code. MDIO changes only while MDC is low, and the controller samples incoming read data on the rising MDC edge.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset every register reads 0, `mdc` is low and `mdio_oe` is low.
- R2: A bus write to register 3 (write data) while idle and not in management reset starts a write frame, and busy (indicator bit 0) is set in the next cycle, well within 30 clocks.
- R3: A write frame is 32 ones, start 01, opcode 01, PHY address from address-register bits 12:8, register address from bits 4:0, turnaround 10, and then the 16 data bits MSB first. `mdio_oe` is high for all 64 bits, and each bit is stable at the rising MDC edge.
- R4: Writing register 1 (command) with bit 0 set, when the stored bit 0 was 0, starts a read while idle. The frame carries start 01 and opcode 10. `mdio_oe` is released from bit 46 (turnaround) to the end, and bits 48..63 are sampled from `mdio_i` on rising MDC edges into register 4 (read data).
- R5: Not-valid (indicator bit 2) sets when a read starts. It clears in the cycle the read-data register is loaded, together with busy.
- R6: Configuration bits 5:2 hold a code c that gives an MDC period of 4*(c+2) system clocks, with MDC high for half of it. Code 8 (register value 0x20) therefore divides by 40. MDC is low whenever the controller is idle.
- R7: While configuration bit 15 is set, any transaction is aborted, busy and not-valid read 0, `mdc` and `mdio_oe` are low, and write-data or read requests start nothing. A write to the write-data register in this state leaves it unchanged.
- R8: Start requests made while busy are ignored: the frame in flight is unchanged, the write-data register keeps its value and no read starts.
- R9: Command bit 1 (scan) is stored and reads back but starts no frame. Link-fail (indicator bit 3) reads 0.
- R10: Register map: 0 configuration, 1 command (bits 1:0), 2 address (only bits 12:8 and 4:0 stored), 3 write data, 4 read data, 5 indicator. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Register read value (combinational from reg_addr) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
A wrong bit counter or a wrong frame latch shows up as a miscompared serial frame at the PHY side, and it shows within a single transaction of 64 MDC periods. A stuck busy or not-valid flag is seen as soon as the indicator register is polled after completion. A wrong divider count shows as a wrong MDC period or duty, which is already measurable on the second rising edge. A management reset that fails to abort leaves MDC toggling or busy set, and the very next indicator read after setting the bit exposes it.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int DATA_W     = 16;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  typedef enum logic [2:0] {
    RA_CFG  = 3'd0,
    RA_CMD  = 3'd1,
    RA_ADR  = 3'd2,
    RA_WDAT = 3'd3,
    RA_RDAT = 3'd4,
    RA_IND  = 3'd5
  } reg_addr_e;

  // Serial frame for one transaction, transmitted from bit 63 down.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic              is_read,
    input logic [4:0]        phy,
    input logic [4:0]        regn,
    input logic [DATA_W-1:0] data
  );
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] payload;
    op      = is_read ? 2'b10 : 2'b01;
    ta      = is_read ? 2'b11 : 2'b10;
    payload = is_read ? {DATA_W{1'b1}} : data;
    return {32'hFFFF_FFFF, 2'b01, op, phy, regn, ta, payload};
  endfunction

  // Number of system clocks in each MDC half period for a divider code.
  function automatic logic [7:0] mdc_half(input logic [3:0] code);
    return 8'((code + 8'd2) << 1);
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_mgmt_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;

  assign half = CNT_W'(mdc_half(4'(code)));
  assign tick = en && (cnt_q == half - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  srst,
  input  logic                  start,
  input  logic                  start_is_read,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  tick,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdc,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic                  is_read,
  output logic [IDX_W-1:0]      bit_idx,
  output logic [DATA_W-1:0]     rd_word
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic                  busy_q, phase_q, rd_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] frm_q;
  logic [DATA_W-1:0]     sh_q;
  logic                  rise_ev, fall_ev, sample_ev;

  assign rise_ev   = busy_q && tick && !phase_q;
  assign fall_ev   = busy_q && tick && phase_q;
  assign sample_ev = rise_ev && rd_q && (idx_q >= IDX_W'(DATA_FIRST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; phase_q <= 1'b0; rd_q <= 1'b0;
      idx_q <= '0; frm_q <= '0; sh_q <= '0;
    end else if (srst) begin
      busy_q <= 1'b0; phase_q <= 1'b0; rd_q <= 1'b0;
      idx_q <= '0; sh_q <= '0;
    end else if (start && !busy_q) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      idx_q   <= '0;
      frm_q   <= frame_in;
      rd_q    <= start_is_read;
      sh_q    <= '0;
    end else begin
      if (rise_ev) phase_q <= 1'b1;
      if (sample_ev) sh_q <= {sh_q[DATA_W-2:0], mdio_i};
      if (fall_ev) begin
        phase_q <= 1'b0;
        if (idx_q == LAST_IDX) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  assign busy    = busy_q;
  assign mdc     = phase_q;
  assign done    = fall_ev && (idx_q == LAST_IDX);
  assign is_read = rd_q;
  assign bit_idx = idx_q;
  assign rd_word = sh_q;
  assign mdio_o  = busy_q ? frm_q[LAST_IDX - idx_q] : 1'b1;
  assign mdio_oe = busy_q && !(rd_q && (idx_q >= IDX_W'(TA_FIRST)));
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int          RST_BIT  = 15;
  localparam int          CODE_LSB = 2;
  localparam logic [15:0] ADR_MASK = 16'h1F1F;

  logic [DATA_W-1:0] cfg_q, adr_q, wdat_q, rdat_q;
  logic [1:0]        cmd_q;
  logic              nv_q;

  logic                  mgmt_rst, start_wr, start_rd, start_any;
  logic                  eng_busy, eng_done, eng_is_read, tick;
  logic [IDX_W-1:0]      eng_idx;
  logic [DATA_W-1:0]     eng_word;
  logic [FRAME_BITS-1:0] frame_next;

  assign mgmt_rst   = cfg_q[RST_BIT];
  assign start_wr   = reg_we && (reg_addr == RA_WDAT) && !eng_busy && !mgmt_rst;
  assign start_rd   = reg_we && (reg_addr == RA_CMD) && reg_wdata[0] && !cmd_q[0]
                      && !eng_busy && !mgmt_rst;
  assign start_any  = start_wr || start_rd;
  assign frame_next = build_frame(start_rd, adr_q[12:8], adr_q[4:0], reg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; adr_q <= '0; wdat_q <= '0; rdat_q <= '0;
      cmd_q <= '0; nv_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RA_CFG) cfg_q <= reg_wdata;
      if (reg_we && reg_addr == RA_CMD) cmd_q <= reg_wdata[1:0];
      if (reg_we && reg_addr == RA_ADR) adr_q <= reg_wdata & ADR_MASK;
      if (start_wr) wdat_q <= reg_wdata;
      if (eng_done && eng_is_read) rdat_q <= eng_word;
      if (mgmt_rst)                     nv_q <= 1'b0;
      else if (start_rd)                nv_q <= 1'b1;
      else if (eng_done && eng_is_read) nv_q <= 1'b0;
    end
  end

  mdio_clk_div #(.CODE_W(CODE_W), .CNT_W(CNT_W)) i_div (
    .clk(clk), .rst_n(rst_n), .en(eng_busy),
    .code(cfg_q[CODE_LSB +: CODE_W]), .tick(tick)
  );

  mdio_frame_eng i_eng (
    .clk(clk), .rst_n(rst_n), .srst(mgmt_rst),
    .start(start_any), .start_is_read(start_rd), .frame_in(frame_next),
    .tick(tick), .mdio_i(mdio_i),
    .busy(eng_busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(eng_done), .is_read(eng_is_read), .bit_idx(eng_idx), .rd_word(eng_word)
  );

  always_comb begin
    case (reg_addr)
      RA_CFG:  reg_rdata = cfg_q;
      RA_CMD:  reg_rdata = {14'd0, cmd_q};
      RA_ADR:  reg_rdata = adr_q;
      RA_WDAT: reg_rdata = wdat_q;
      RA_RDAT: reg_rdata = rdat_q;
      RA_IND:  reg_rdata = {12'd0, 1'b0, nv_q, 1'b0, eng_busy};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mdc,
  input logic       mdio_oe,
  input logic       nv,
  input logic       mgmt_rst,
  input logic       start_wr,
  input logic       start_rd,
  input logic       done,
  input logic       is_read
);
  a_r2_busy_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> busy);

  a_r4_read_raises_nv: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |=> (nv && busy));

  a_r5_nv_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    nv |-> busy);

  a_r5_done_clears_nv: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_read && !mgmt_rst) |=> (!nv && !busy));

  a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r7_reset_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_rst |=> (!busy && !nv));

  a_r4_bus_released_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_read) |-> !mdio_oe);
endmodule

bind mdio_mgmt mdio_mgmt_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(eng_busy), .mdc(mdc), .mdio_oe(mdio_oe),
  .nv(nv_q), .mgmt_rst(mgmt_rst), .start_wr(start_wr), .start_rd(start_rd),
  .done(eng_done), .is_read(eng_is_read)
);

// File: tb/test_mdio_mgmt.sv
module test_mdio_mgmt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  // PHY-side capture
  int          bitcnt = 0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_rdval = 16'h0;
  time         t_rise = 0, t_prev_rise = 0, t_fall = 0;
  int          period_clk = 0, high_clk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt i_mdio_mgmt (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    if (bitcnt < 64) begin
      cap_o[63-bitcnt]  = mdio_o;
      cap_oe[63-bitcnt] = mdio_oe;
    end
    t_prev_rise = t_rise;
    t_rise = $time;
    if (bitcnt > 0) period_clk = int'((t_rise - t_prev_rise) / CLK_PERIOD);
    bitcnt++;
  end

  always @(negedge mdc) begin
    t_fall = $time;
    high_clk = int'((t_fall - t_rise) / CLK_PERIOD);
    if (bitcnt >= 48 && bitcnt < 64) mdio_i = phy_rdval[63-bitcnt];
    else mdio_i = 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd5, v);
      if (v[0] == 1'b0) return;
    end
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 register reset value", 64'(v), 64'h0);
    end
    check("R1 mdc and oe low", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic t_regmap();
    logic [15:0] v;
    wr(3'd2, 16'hFFFF);
    rd(3'd2, v);
    check("R10 address field mask", 64'(v), 64'h1F1F);
    wr(3'd6, 16'h1234);
    rd(3'd6, v);
    check("R10 unmapped reads 0", 64'(v), 64'h0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, input logic [3:0] code);
    logic [15:0] v;
    wr(3'd0, {10'd0, code, 2'd0});
    wr(3'd2, {3'd0, phy, 3'd0, rg});
    bitcnt = 0;
    wr(3'd3, d);
    rd(3'd5, v);
    check("R2 busy soon after write start", 64'(v[0]), 64'd1);
    wait_idle();
    check("R3 write frame bits", cap_o, {32'hFFFF_FFFF, 4'b0101, phy, rg, 2'b10, d});
    check("R3 oe for whole write", cap_oe, {64{1'b1}});
    check("R3 bit count", 64'(bitcnt), 64'd64);
    check("R6 mdc period", 64'(period_clk), 64'(4 * (int'(code) + 2)));
    check("R6 mdc high half", 64'(high_clk), 64'(2 * (int'(code) + 2)));
    check("R6 mdc idle low", 64'(mdc), 64'd0);
    rd(3'd3, v);
    check("R10 write data readback", 64'(v), 64'(d));
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] pv);
    logic [15:0] v;
    wr(3'd2, {3'd0, phy, 3'd0, rg});
    phy_rdval = pv;
    bitcnt = 0;
    wr(3'd1, 16'h0001);
    rd(3'd5, v);
    check("R5 not-valid and busy at read start", 64'(v[2:0]), 64'h5);
    wait_idle();
    rd(3'd5, v);
    check("R5 not-valid cleared after read", 64'(v), 64'h0);
    check("R4 read header bits", 64'(cap_o[63:18]), 64'({32'hFFFF_FFFF, 4'b0110, phy, rg}));
    check("R4 oe released from turnaround", cap_oe, {{46{1'b1}}, 18'd0});
    rd(3'd4, v);
    check("R4 read data captured", 64'(v), 64'(pv));
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] v;
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0305);
    bitcnt = 0;
    wr(3'd3, 16'hA5C3);
    repeat (20) @(negedge clk);
    wr(3'd3, 16'h1111);
    wr(3'd1, 16'h0001);
    rd(3'd5, v);
    check("R8 read request while busy sets no not-valid", 64'(v[2]), 64'd0);
    wait_idle();
    check("R8 frame unchanged", cap_o, {32'hFFFF_FFFF, 4'b0101, 5'd3, 5'd5, 2'b10, 16'hA5C3});
    rd(3'd3, v);
    check("R8 write data kept", 64'(v), 64'hA5C3);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_mgmt_reset();
    logic [15:0] v;
    wr(3'd0, 16'h0000);
    bitcnt = 0;
    wr(3'd3, 16'h7E7E);
    repeat (100) @(negedge clk);
    wr(3'd0, 16'h8000);
    rd(3'd5, v);
    check("R7 busy cleared by mgmt reset", 64'(v), 64'h0);
    check("R7 mdc and oe low in reset", {62'd0, mdc, mdio_oe}, 64'd0);
    wr(3'd3, 16'h0F0F);
    wr(3'd1, 16'h0001);
    repeat (10) @(negedge clk);
    rd(3'd5, v);
    check("R7 no start in reset", 64'(v), 64'h0);
    rd(3'd3, v);
    check("R7 write data unchanged in reset", 64'(v), 64'h7E7E);
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_scan();
    logic [15:0] v;
    bitcnt = 0;
    wr(3'd1, 16'h0002);
    repeat (50) @(negedge clk);
    rd(3'd5, v);
    check("R9 scan starts nothing, link-fail 0", 64'(v), 64'h0);
    check("R9 no mdc edge", 64'(bitcnt), 64'd0);
    rd(3'd1, v);
    check("R9 scan bit stored", 64'(v), 64'h2);
    wr(3'd1, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_regmap();
    t_write(5'h01, 5'h00, 16'h8001, 4'd0);
    t_write(5'h1F, 5'h1F, 16'h5AA5, 4'd8);
    t_read(5'h02, 5'h11, 16'hBEEF);
    t_read(5'h1A, 5'h05, 16'h0001);
    t_busy_ignore();
    t_mgmt_reset();
    t_write(5'h04, 5'h09, 16'hFFFE, 4'd1);
    t_scan();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule